// File: doc/BRIEF.md
# Trap Return Privilege Sequencer

This block carries out the two trap-return operations of a privileged processor core: the return to the supervisor level and the return to the machine level. It owns the current privilege level (user = 2'd0, supervisor = 2'd1, machine = 2'd3) and the stacked interrupt-enable state that those returns consume. That state is the supervisor and machine enables, their saved copies, the saved previous privilege for each level, and a control bit that forbids supervisor returns. When a return is requested, the block checks that the return is legal. It presents the matching saved exception PC as the next fetch address. If no exception is raised, it pops the interrupt-enable stack and switches privilege on the same clock edge.

The rest of the core writes the whole state through a single load port, as trap entry and register writes do. The saved exception PCs and a static flag for compressed-instruction support come in from outside. Outputs give the next PC, an exception strobe with a standard cause code, a strobe marking a successful return, and the current value of every field.

Top module: `trp_ret_seq`

## Requirements
- R1: After reset, privilege is machine (2'd3), and the enables, saved enables, saved privileges and the return-forbid bit are all 0.
- R2: With `ld_i` high, every state field takes its `ld_*` value at the next edge. This wins over a return requested in the same cycle, although that return's combinational outputs are still produced.
- R3: A supervisor return at user privilege, or a machine return below machine privilege, raises cause 2 (illegal instruction). This check has the highest priority.
- R4: When `rvc_en_i` is 0, a privilege-legal return whose selected exception PC has bit 1 or bit 0 set raises cause 0 (misaligned target). When `rvc_en_i` is 1, no alignment check is made.
- R5: A supervisor return with `tsr_o` = 1 that passes R3 and R4 raises cause 2. A machine return ignores `tsr_o`.
- R6: A successful supervisor return sets the supervisor enable to its saved copy, clears the saved copy, sets the saved supervisor privilege to user, and sets privilege to {1'b0, old saved supervisor privilege}.
- R7: A successful machine return sets the machine enable to its saved copy, clears the saved copy, sets the saved machine privilege to user, and sets privilege to the old saved machine privilege.
- R8: During a request, `next_pc_o` equals `sepc_i` for a supervisor return and `mepc_i` for a machine return, in the same cycle.
- R9: A return that raises an exception changes no state field.
- R10: When both return requests are high, the block treats the cycle as a machine return.
- R11: `ret_ok_o` is high exactly when a request is present and no exception is raised. `exc_vld_o` is never high without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sret_i | input | 1 | Supervisor return request |
| mret_i | input | 1 | Machine return request |
| sepc_i | input | XLEN | Saved supervisor exception PC |
| mepc_i | input | XLEN | Saved machine exception PC |
| rvc_en_i | input | 1 | Compressed instructions supported (static) |
| ld_i | input | 1 | Load all state fields |
| ld_priv_i | input | 2 | Load value, privilege |
| ld_sie_i | input | 1 | Load value, supervisor enable |
| ld_spie_i | input | 1 | Load value, saved supervisor enable |
| ld_spp_i | input | 1 | Load value, saved supervisor privilege |
| ld_mie_i | input | 1 | Load value, machine enable |
| ld_mpie_i | input | 1 | Load value, saved machine enable |
| ld_mpp_i | input | 2 | Load value, saved machine privilege |
| ld_tsr_i | input | 1 | Load value, supervisor-return forbid bit |
| next_pc_o | output | XLEN | Return target |
| exc_vld_o | output | 1 | Exception raised by the request |
| exc_code_o | output | CAUSE_W | Exception cause |
| ret_ok_o | output | 1 | Return commits at this edge |
| priv_o | output | 2 | Current privilege |
| sie_o | output | 1 | Supervisor enable |
| spie_o | output | 1 | Saved supervisor enable |
| spp_o | output | 1 | Saved supervisor privilege |
| mie_o | output | 1 | Machine enable |
| mpie_o | output | 1 | Saved machine enable |
| mpp_o | output | 2 | Saved machine privilege |
| tsr_o | output | 1 | Supervisor-return forbid bit |

## Verification
Two kinds of cycle can collide. The first is a state load and a return request in the same cycle. The bench provokes it directly, for example a load that sets supervisor privilege alongside a supervisor return from a user-level state. It checks that the return's exception output reflects the old state while the registers take the loaded values. The second is several exception causes on one request: low privilege with a misaligned target, or the forbid bit with a misaligned target. The cause reported must follow the fixed priority. A long run of random loads and requests, compared every cycle against a behavioural model, widens both cases.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int CAUSE_MISALIGN = 0;
  localparam int CAUSE_ILLEGAL  = 2;

  typedef struct packed {
    logic [1:0] priv;
    logic       sie;
    logic       spie;
    logic       spp;
    logic       mie;
    logic       mpie;
    logic [1:0] mpp;
    logic       tsr;
  } trp_state_t;

  localparam trp_state_t STATE_RST = '{priv: PRV_M, mpp: PRV_U, default: 1'b0};
endpackage

// File: rtl/trp_ret_check.sv
module trp_ret_check
  import trp_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic               sret_i,
  input  logic               mret_i,
  input  logic               rvc_en_i,
  input  logic [1:0]         priv_i,
  input  logic               tsr_i,
  input  logic [1:0]         sepc_lo_i,
  input  logic [1:0]         mepc_lo_i,
  output logic               use_m_o,
  output logic               exc_vld_o,
  output logic [CAUSE_W-1:0] exc_code_o
);
  logic       req;
  logic [1:0] epc_lo;
  logic [1:0] min_priv;
  logic       priv_low, mis, tsr_trap;

  assign req      = sret_i | mret_i;
  assign use_m_o  = mret_i;
  assign epc_lo   = use_m_o ? mepc_lo_i : sepc_lo_i;
  assign min_priv = use_m_o ? PRV_M : PRV_S;
  assign priv_low = priv_i < min_priv;
  assign mis      = !rvc_en_i && (epc_lo != 2'b00);
  assign tsr_trap = !use_m_o && tsr_i;

  // fixed priority: privilege, alignment, forbid bit
  always_comb begin
    exc_vld_o  = 1'b0;
    exc_code_o = '0;
    if (req) begin
      if (priv_low) begin
        exc_vld_o  = 1'b1;
        exc_code_o = CAUSE_W'(CAUSE_ILLEGAL);
      end else if (mis) begin
        exc_vld_o  = 1'b1;
        exc_code_o = CAUSE_W'(CAUSE_MISALIGN);
      end else if (tsr_trap) begin
        exc_vld_o  = 1'b1;
        exc_code_o = CAUSE_W'(CAUSE_ILLEGAL);
      end
    end
  end
endmodule

// File: rtl/trp_ret_update.sv
module trp_ret_update
  import trp_pkg::*;
(
  input  trp_state_t cur_i,
  input  logic       use_m_i,
  output trp_state_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (use_m_i) begin
      nxt_o.mie  = cur_i.mpie;
      nxt_o.mpie = 1'b0;
      nxt_o.mpp  = PRV_U;
      nxt_o.priv = cur_i.mpp;
    end else begin
      nxt_o.sie  = cur_i.spie;
      nxt_o.spie = 1'b0;
      nxt_o.spp  = 1'b0;
      nxt_o.priv = {1'b0, cur_i.spp};
    end
  end
endmodule

// File: rtl/trp_ret_seq.sv
module trp_ret_seq
  import trp_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sret_i,
  input  logic               mret_i,
  input  logic [XLEN-1:0]    sepc_i,
  input  logic [XLEN-1:0]    mepc_i,
  input  logic               rvc_en_i,
  input  logic               ld_i,
  input  logic [1:0]         ld_priv_i,
  input  logic               ld_sie_i,
  input  logic               ld_spie_i,
  input  logic               ld_spp_i,
  input  logic               ld_mie_i,
  input  logic               ld_mpie_i,
  input  logic [1:0]         ld_mpp_i,
  input  logic               ld_tsr_i,
  output logic [XLEN-1:0]    next_pc_o,
  output logic               exc_vld_o,
  output logic [CAUSE_W-1:0] exc_code_o,
  output logic               ret_ok_o,
  output logic [1:0]         priv_o,
  output logic               sie_o,
  output logic               spie_o,
  output logic               spp_o,
  output logic               mie_o,
  output logic               mpie_o,
  output logic [1:0]         mpp_o,
  output logic               tsr_o
);
  trp_state_t state_q, state_upd, state_ld;
  logic       use_m, req;

  trp_ret_check #(.CAUSE_W(CAUSE_W)) u_check (
    .sret_i     (sret_i),
    .mret_i     (mret_i),
    .rvc_en_i   (rvc_en_i),
    .priv_i     (state_q.priv),
    .tsr_i      (state_q.tsr),
    .sepc_lo_i  (sepc_i[1:0]),
    .mepc_lo_i  (mepc_i[1:0]),
    .use_m_o    (use_m),
    .exc_vld_o  (exc_vld_o),
    .exc_code_o (exc_code_o)
  );

  trp_ret_update u_update (
    .cur_i   (state_q),
    .use_m_i (use_m),
    .nxt_o   (state_upd)
  );

  assign req       = sret_i | mret_i;
  assign ret_ok_o  = req & ~exc_vld_o;
  assign next_pc_o = use_m ? mepc_i : sepc_i;

  always_comb begin
    state_ld      = '0;
    state_ld.priv = ld_priv_i;
    state_ld.sie  = ld_sie_i;
    state_ld.spie = ld_spie_i;
    state_ld.spp  = ld_spp_i;
    state_ld.mie  = ld_mie_i;
    state_ld.mpie = ld_mpie_i;
    state_ld.mpp  = ld_mpp_i;
    state_ld.tsr  = ld_tsr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       state_q <= STATE_RST;
    else if (ld_i)     state_q <= state_ld;
    else if (ret_ok_o) state_q <= state_upd;
  end

  assign priv_o = state_q.priv;
  assign sie_o  = state_q.sie;
  assign spie_o = state_q.spie;
  assign spp_o  = state_q.spp;
  assign mie_o  = state_q.mie;
  assign mpie_o = state_q.mpie;
  assign mpp_o  = state_q.mpp;
  assign tsr_o  = state_q.tsr;
endmodule

// File: rtl/trp_ret_sva.sv
module trp_ret_sva #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sret_i,
  input logic               mret_i,
  input logic [XLEN-1:0]    sepc_i,
  input logic [XLEN-1:0]    mepc_i,
  input logic               rvc_en_i,
  input logic               ld_i,
  input logic [1:0]         ld_priv_i,
  input logic [XLEN-1:0]    next_pc_o,
  input logic               exc_vld_o,
  input logic [CAUSE_W-1:0] exc_code_o,
  input logic               ret_ok_o,
  input logic [1:0]         priv_o,
  input logic               sie_o,
  input logic               spie_o,
  input logic               spp_o,
  input logic               mie_o,
  input logic               mpie_o,
  input logic [1:0]         mpp_o,
  input logic               tsr_o
);
  logic s_only;
  assign s_only = sret_i && !mret_i;

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> priv_o == $past(ld_priv_i)); // R2

  AST_LOW_PRIV_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((s_only && priv_o == 2'd0) || (mret_i && priv_o != 2'd3))
      |-> exc_vld_o && exc_code_o == CAUSE_W'(2)); // R3

  AST_MISALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && priv_o == 2'd3 && !rvc_en_i && mepc_i[1:0] != 2'b00)
      |-> exc_vld_o && exc_code_o == '0); // R4

  AST_TSR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_only && tsr_o) |-> exc_vld_o); // R5

  AST_SRET_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_only && ret_ok_o && !ld_i) |=>
      sie_o == $past(spie_o) && !spie_o && !spp_o && priv_o == {1'b0, $past(spp_o)}); // R6

  AST_MRET_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && ret_ok_o && !ld_i) |=>
      mie_o == $past(mpie_o) && !mpie_o && mpp_o == 2'd0 && priv_o == $past(mpp_o)); // R7

  AST_NEXT_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sret_i || mret_i) |-> next_pc_o == (mret_i ? mepc_i : sepc_i)); // R8

  AST_EXC_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_vld_o && !ld_i) |=> $stable(priv_o) && $stable(sie_o) && $stable(spie_o)
      && $stable(spp_o) && $stable(mie_o) && $stable(mpie_o) && $stable(mpp_o)); // R9

  AST_OK_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ret_ok_o && exc_vld_o) && (exc_vld_o -> (sret_i || mret_i))); // R11
endmodule

bind trp_ret_seq trp_ret_sva #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_sva (.*);

// File: tb/tb_trp_ret_seq.sv
`timescale 1ns/1ps
module tb_trp_ret_seq;
  localparam int XLEN = 32;
  localparam int CW   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sret = 0, mret = 0, rvc = 0, ld = 0;
  logic [XLEN-1:0] sepc = '0, mepc = '0;
  logic [1:0] l_priv = 0, l_mpp = 0;
  logic l_sie = 0, l_spie = 0, l_spp = 0, l_mie = 0, l_mpie = 0, l_tsr = 0;
  logic [XLEN-1:0] next_pc;
  logic exc_vld, ret_ok;
  logic [CW-1:0] exc_code;
  logic [1:0] priv, mpp;
  logic sie, spie, spp, mie, mpie, tsr;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int r_priv, r_sie, r_spie, r_spp, r_mie, r_mpie, r_mpp, r_tsr;

  always #10 clk = ~clk;

  trp_ret_seq #(.XLEN(XLEN), .CAUSE_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sret_i(sret), .mret_i(mret),
    .sepc_i(sepc), .mepc_i(mepc), .rvc_en_i(rvc), .ld_i(ld),
    .ld_priv_i(l_priv), .ld_sie_i(l_sie), .ld_spie_i(l_spie), .ld_spp_i(l_spp),
    .ld_mie_i(l_mie), .ld_mpie_i(l_mpie), .ld_mpp_i(l_mpp), .ld_tsr_i(l_tsr),
    .next_pc_o(next_pc), .exc_vld_o(exc_vld), .exc_code_o(exc_code), .ret_ok_o(ret_ok),
    .priv_o(priv), .sie_o(sie), .spie_o(spie), .spp_o(spp), .mie_o(mie),
    .mpie_o(mpie), .mpp_o(mpp), .tsr_o(tsr)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk(tag, "priv", priv, r_priv); chk(tag, "sie", sie, r_sie);
    chk(tag, "spie", spie, r_spie); chk(tag, "spp", spp, r_spp);
    chk(tag, "mie", mie, r_mie);    chk(tag, "mpie", mpie, r_mpie);
    chk(tag, "mpp", mpp, r_mpp);    chk(tag, "tsr", tsr, r_tsr);
  endtask

  // one clock: inputs already driven at negedge
  task automatic cyc(string tag);
    bit is_m, req, e;
    int code, lo;
    #2;
    req = sret || mret;
    is_m = mret;
    lo = is_m ? int'(mepc[1:0]) : int'(sepc[1:0]);
    e = 0; code = 0;
    if (req) begin
      if (is_m ? (r_priv != 3) : (r_priv == 0)) begin e = 1; code = 2; end // R3 / R10
      else if (!rvc && lo != 0) begin e = 1; code = 0; end                // R4
      else if (!is_m && r_tsr == 1) begin e = 1; code = 2; end            // R5
    end
    chk(tag, "exc_vld", exc_vld, e);
    if (e) chk(tag, "exc_code", exc_code, code);
    chk(tag, "ret_ok", ret_ok, req && !e);                                // R11
    if (req) chk(tag, "next_pc", next_pc, is_m ? mepc : sepc);            // R8
    @(posedge clk);
    if (ld) begin                                                         // R2
      r_priv = l_priv; r_sie = l_sie; r_spie = l_spie; r_spp = l_spp;
      r_mie = l_mie; r_mpie = l_mpie; r_mpp = l_mpp; r_tsr = l_tsr;
    end else if (req && !e) begin
      if (is_m) begin                                                     // R7
        r_sie = r_sie; r_mie = r_mpie; r_mpie = 0; r_priv = r_mpp; r_mpp = 0;
      end else begin                                                      // R6
        r_sie = r_spie; r_spie = 0; r_priv = r_spp; r_spp = 0;
      end
    end                                                                   // R9: else unchanged
    @(negedge clk);
    chk_state(tag);
    sret = 0; mret = 0; ld = 0;
  endtask

  task automatic load(int p, int si, int sp, int ss, int mi, int mp, int mm, int t);
    ld = 1; l_priv = 2'(p); l_sie = 1'(si); l_spie = 1'(sp); l_spp = 1'(ss);
    l_mie = 1'(mi); l_mpie = 1'(mp); l_mpp = 2'(mm); l_tsr = 1'(t);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    r_priv = 3; r_sie = 0; r_spie = 0; r_spp = 0; r_mie = 0; r_mpie = 0; r_mpp = 0; r_tsr = 0;
    repeat (3) @(negedge clk);
    chk_state("R1");
    rst_n = 1;
    @(negedge clk);
    chk_state("R1");

    sepc = 32'h0000_1000; mepc = 32'h0000_2000;
    // R2 load supervisor state, then R6 sret from S to U
    load(1, 0, 1, 0, 0, 0, 0, 0); cyc("R2");
    sret = 1; cyc("R6");
    // R3 sret at U illegal, state held (R9)
    sret = 1; cyc("R3");
    // R3 mret from S illegal
    load(1, 1, 1, 1, 0, 1, 1, 0); cyc("R2");
    mret = 1; cyc("R3");
    // R6 sret with spp=1 stays in S
    sret = 1; cyc("R6");
    // R7 mret from M to S
    load(3, 0, 0, 0, 0, 1, 1, 0); cyc("R2");
    mret = 1; cyc("R7");
    // R7 mret to M with mpp=3
    load(3, 0, 0, 0, 1, 0, 3, 0); cyc("R2");
    mret = 1; cyc("R7");
    // R4 misaligned, then R3 priority over misalignment
    load(3, 0, 1, 1, 0, 1, 0, 0); cyc("R2");
    mepc = 32'h0000_2002; mret = 1; cyc("R4");
    sepc = 32'h0000_1001; sret = 1; cyc("R4");
    rvc = 1; mret = 1; cyc("R4");
    rvc = 0;
    load(0, 0, 0, 0, 0, 0, 0, 0); cyc("R2");
    mret = 1; cyc("R3");
    // R5 forbid bit: misaligned wins, then illegal, mret unaffected
    load(3, 0, 1, 0, 0, 1, 1, 1); cyc("R2");
    sret = 1; cyc("R5");
    sepc = 32'h0000_1000; sret = 1; cyc("R5");
    mepc = 32'h0000_2000; mret = 1; cyc("R5");
    // R10 both requests
    load(3, 0, 1, 1, 0, 1, 1, 0); cyc("R2");
    sret = 1; mret = 1; cyc("R10");
    // R2 load and return in the same cycle
    load(0, 0, 1, 1, 0, 0, 0, 0); cyc("R2");
    sret = 1; load(1, 1, 0, 1, 1, 1, 3, 0); cyc("R2");
    mret = 1; load(3, 0, 0, 0, 0, 0, 0, 1); cyc("R2");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      sret = 1'($urandom_range(0, 1));
      mret = 1'($urandom_range(0, 2) == 0);
      rvc  = 1'($urandom_range(0, 3) == 0);
      sepc = $urandom; mepc = $urandom;
      if ($urandom_range(0, 4) == 0) begin
        int p;
        p = $urandom_range(0, 2);
        load(p == 2 ? 3 : p, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1) ? 3 : $urandom_range(0, 1),
             $urandom_range(0, 3) == 0);
      end
      cyc("R9");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule